// File: doc/BRIEF.md
# Hold/Toggle Duty-Cycle Sequencer

This block sits between the per-pattern toggle control register of a low-power pseudorandom pattern generator and the hold latches that feed its phase shifter. It splits the shift phase of every test pattern into alternating toggle and hold periods. During a toggle period the per-latch control bits reach the latch enables unchanged. During a hold period every latch enable is forced low, so the phase shifter inputs freeze and the scan chains receive constant data.

Two programmable 4-bit lengths set the duty cycle. A value v gives a period of v+1 shift cycles. Both values are copied into shadow registers when a pattern starts, so later writes to the programming inputs take effect only at the next pattern start. The current mode is a T-type flip-flop. A down-counter pulses its T input for one cycle when the active period expires, and reloads with the length of the new mode. The counter and the mode move only on shift cycles. They stay frozen when shift enable is low or when capture is signalled.

Top module: `dgs_top`

## Requirements
- R1: After a synchronous active-low reset, `mode_toggle` is 1 and `latch_en` equals `ctrl_bits`.
- R2: While `mode_toggle` is 1 (toggle), `latch_en` equals `ctrl_bits` bit for bit.
- R3: While `mode_toggle` is 0 (hold), every bit of `latch_en` is 0 whatever `ctrl_bits` holds, so successive hold cycles present identical enables.
- R4: After a pattern start, the mode stays toggle for exactly T+1 advancing cycles. An advancing cycle is a clock edge with `shift_en`=1 and `capture`=0. T is the toggle length sampled at the start.
- R5: Each hold period lasts exactly H+1 advancing cycles, where H is the hold length sampled at the start. Periods then alternate toggle (T+1) and hold (H+1) until the next start.
- R6: A programmed length of 0 gives a period of exactly one advancing cycle, and 15 gives sixteen.
- R7: A clock edge with `shift_en`=0 changes neither the mode nor the position within the period.
- R8: A clock edge with `capture`=1 changes neither the mode nor the position within the period, even when `shift_en` is 1.
- R9: Changes on `hold_len_in` or `tog_len_in` after a pattern start have no effect on period lengths until the next `pattern_start`.
- R10: `pattern_start` sampled at an edge forces toggle mode from any state and restarts the sequence with the lengths present on the inputs at that edge. It takes priority over `shift_en` and `capture`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pattern_start | input | 1 | One-cycle pulse marking the start of a new pattern's shift phase |
| shift_en | input | 1 | High on shift cycles |
| capture | input | 1 | High during the capture phase; freezes sequencing |
| hold_len_in | input | 4 | Programmed hold length (period = value+1) |
| tog_len_in | input | 4 | Programmed toggle length (period = value+1) |
| ctrl_bits | input | N_EN (8) | Per-pattern toggle control register bits |
| latch_en | output | N_EN (8) | Gated hold-latch enables |
| mode_toggle | output | 1 | Current mode: 1 toggle, 0 hold |

## Verification
The hardest situation to reach is a period boundary that falls next to a stalled edge (shift enable low or capture high) while the programming inputs are being changed. A wrong stall or a reload from the live inputs would only shift the boundary by a cycle. The bench sweeps all 256 pairs of toggle and hold lengths. It interleaves stalls and captures on a fixed modulo schedule and scrambles the programming inputs after every start. Each pattern is cut short by the next start at an arbitrary phase. A model counts advancing cycles and places every expected boundary arithmetically.

// File: rtl/dgs_pkg.sv
// Package: shared constants for the hold/toggle duty-cycle sequencer.
// Assumes: mode is a single bit, 1 = toggle (enables pass), 0 = hold.
package dgs_pkg;
    localparam logic MODE_HOLD   = 1'b0;
    localparam logic MODE_TOGGLE = 1'b1;
    localparam int   LEN_W_DEF   = 4;
    localparam int   N_EN_DEF    = 8;
endpackage

// File: rtl/dgs_shadow.sv
// Module: dgs_shadow
// Copies the programmed hold and toggle lengths into local registers at a
// pattern start and keeps them unchanged for the rest of the pattern,
// capture included. Assumes load is a single-cycle pulse.
module dgs_shadow #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] hold_in,
    input  logic [LEN_W-1:0] tog_in,
    output logic [LEN_W-1:0] hold_q,
    output logic [LEN_W-1:0] tog_q
);
    // Capture the programmed lengths only on a pattern start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            tog_q  <= '0;
        end else if (load) begin
            hold_q <= hold_in;
            tog_q  <= tog_in;
        end
    end
endmodule

// File: rtl/dgs_period_cnt.sv
// Module: dgs_period_cnt
// Down-counter that measures the active period. It loads the toggle length
// at a pattern start. On each advancing cycle it counts down, and at zero it
// raises t_pulse for that cycle and reloads with the length of the mode
// being entered. Assumes mode_now is the mode before the flip.
module dgs_period_cnt #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             advance,
    input  logic [LEN_W-1:0] start_len,
    input  logic [LEN_W-1:0] hold_len,
    input  logic [LEN_W-1:0] tog_len,
    input  logic             mode_now,
    output logic             t_pulse
);
    import dgs_pkg::*;

    logic [LEN_W-1:0] cnt_q;
    logic             at_zero;
    logic [LEN_W-1:0] next_len;

    assign at_zero = (cnt_q == '0);
    // Length of the mode entered on a flip: leaving toggle enters hold.
    assign next_len = (mode_now == MODE_TOGGLE) ? hold_len : tog_len;
    // Flip request: the period expires on an advancing cycle with no restart.
    assign t_pulse  = advance && at_zero && !start;

    // Count the active period, restart on pattern start, reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= start_len;
        end else if (advance) begin
            if (at_zero) cnt_q <= next_len;
            else         cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/dgs_tflop.sv
// Module: dgs_tflop
// T-type mode flip-flop. It inverts when t is 1 and is forced to toggle mode
// on a pattern start or reset. Assumes t is never high in the start cycle.
module dgs_tflop (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic t,
    output logic mode_q
);
    import dgs_pkg::*;

    // Hold the current mode; invert on t, force toggle on start.
    always_ff @(posedge clk) begin
        if (!rst_n)     mode_q <= MODE_TOGGLE;
        else if (start) mode_q <= MODE_TOGGLE;
        else if (t)     mode_q <= ~mode_q;
    end
endmodule

// File: rtl/dgs_gate.sv
// Module: dgs_gate
// ANDs each control bit with the mode bit, so a hold mode clears every
// enable. Purely combinational.
module dgs_gate #(
    parameter int N_EN = 8
) (
    input  logic [N_EN-1:0] ctrl,
    input  logic            mode,
    output logic [N_EN-1:0] en
);
    for (genvar i = 0; i < N_EN; i++) begin : g_bit
        // One AND gate per latch enable.
        assign en[i] = ctrl[i] & mode;
    end
endmodule

// File: rtl/dgs_top.sv
// Module: dgs_top
// Hold/toggle duty-cycle sequencer. It imposes alternating toggle (T+1) and
// hold (H+1) periods on the latch enables of a low-toggle pattern generator.
// Assumes pattern_start is a one-cycle pulse and that sequencing advances
// only on edges with shift_en=1 and capture=0.
module dgs_top #(
    parameter int N_EN  = dgs_pkg::N_EN_DEF,
    parameter int LEN_W = dgs_pkg::LEN_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pattern_start,
    input  logic             shift_en,
    input  logic             capture,
    input  logic [LEN_W-1:0] hold_len_in,
    input  logic [LEN_W-1:0] tog_len_in,
    input  logic [N_EN-1:0]  ctrl_bits,
    output logic [N_EN-1:0]  latch_en,
    output logic             mode_toggle
);
    logic [LEN_W-1:0] hold_sh;
    logic [LEN_W-1:0] tog_sh;
    logic             advance;
    logic             t_in;
    logic             mode_q;

    // Advancing cycle: a shift edge outside capture.
    assign advance = shift_en && !capture;

    dgs_shadow #(.LEN_W(LEN_W)) shadow_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pattern_start),
        .hold_in (hold_len_in),
        .tog_in  (tog_len_in),
        .hold_q  (hold_sh),
        .tog_q   (tog_sh)
    );

    dgs_period_cnt #(.LEN_W(LEN_W)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (pattern_start),
        .advance   (advance),
        .start_len (tog_len_in),
        .hold_len  (hold_sh),
        .tog_len   (tog_sh),
        .mode_now  (mode_q),
        .t_pulse   (t_in)
    );

    dgs_tflop tflop_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (pattern_start),
        .t      (t_in),
        .mode_q (mode_q)
    );

    dgs_gate #(.N_EN(N_EN)) gate_i (
        .ctrl (ctrl_bits),
        .mode (mode_q),
        .en   (latch_en)
    );

    assign mode_toggle = mode_q;
endmodule

// File: rtl/dgs_checker.sv
// Module: dgs_checker
// Property checker for dgs_top, attached by bind. Counts advancing cycles
// spent in one mode to bound the period length.
module dgs_checker #(
    parameter int N_EN  = 8,
    parameter int LEN_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pattern_start,
    input logic            shift_en,
    input logic            capture,
    input logic [N_EN-1:0] ctrl_bits,
    input logic [N_EN-1:0] latch_en,
    input logic            mode_toggle
);
    localparam int MAX_RUN = 1 << LEN_W;

    logic [LEN_W+1:0] run_q;
    logic             prev_mode;

    // Track advancing cycles since the last mode change or start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= '0;
            prev_mode <= 1'b1;
        end else begin
            prev_mode <= mode_toggle;
            if (pattern_start || (mode_toggle != prev_mode)) run_q <= '0;
            else if (shift_en && !capture && run_q <= MAX_RUN) run_q <= run_q + 1'b1;
        end
    end

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_toggle |-> (latch_en == ctrl_bits));

    p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_toggle |-> (latch_en == '0));

    p_period_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= MAX_RUN);

    p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !pattern_start) |=> $stable(mode_toggle));

    p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !pattern_start) |=> $stable(mode_toggle));

    p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_start |=> mode_toggle);
endmodule

bind dgs_top dgs_checker #(.N_EN(N_EN), .LEN_W(LEN_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pattern_start (pattern_start),
    .shift_en      (shift_en),
    .capture       (capture),
    .ctrl_bits     (ctrl_bits),
    .latch_en      (latch_en),
    .mode_toggle   (mode_toggle)
);

// File: tb/dgs_top_tb_top.sv
module dgs_top_tb_top;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pattern_start = 1'b0;
    logic       shift_en = 1'b0;
    logic       capture = 1'b0;
    logic [3:0] hold_len_in = '0;
    logic [3:0] tog_len_in = '0;
    logic [N-1:0] ctrl_bits = '0;
    logic [N-1:0] latch_en;
    logic       mode_toggle;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    dgs_top dut_i (
        .clk(clk), .rst_n(rst_n), .pattern_start(pattern_start),
        .shift_en(shift_en), .capture(capture), .hold_len_in(hold_len_in),
        .tog_len_in(tog_len_in), .ctrl_bits(ctrl_bits),
        .latch_en(latch_en), .mode_toggle(mode_toggle)
    );

    always #5 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        int mt, mh, s;
        logic expm;
        mt = 0; mh = 0; s = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ctrl_bits = 8'hA5;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 mode", mode_toggle, 1);
        chk("R1 en", latch_en, 8'hA5);
        for (int t = 0; t < 16; t++) begin
            for (int h = 0; h < 16; h++) begin
                int len;
                len = 30 + ((t * 7 + h * 3) % 17);
                for (int k = 0; k < len; k++) begin
                    @(negedge clk);
                    // drive inputs
                    pattern_start = (k == 0);
                    if (k == 0) begin
                        tog_len_in = t[3:0];
                        hold_len_in = h[3:0];
                    end else begin
                        // R9: scramble programming after start
                        tog_len_in = 4'((k * 5 + h) & 15);
                        hold_len_in = 4'((k * 11 + t) & 15);
                    end
                    shift_en = !((k % 5) == 3);
                    capture = ((k % 11) == 7);
                    ctrl_bits = N'((k * 37 + t * 13 + h) ^ 8'h5C);
                    @(posedge clk);
                    // model update
                    if (pattern_start) begin
                        mt = t; mh = h; s = 0;
                    end else if (shift_en && !capture) begin
                        s = s + 1;
                    end
                    #1;
                    expm = ((s % (mt + mh + 2)) < (mt + 1));
                    if (pattern_start)
                        chk("R10 start", mode_toggle, 1);
                    else if (!shift_en)
                        chk("R7 stall", mode_toggle, expm);
                    else if (capture)
                        chk("R8 capture", mode_toggle, expm);
                    else if (t == 0 || h == 0 || t == 15 || h == 15)
                        chk("R6 edge len", mode_toggle, expm);
                    else if (k > 1)
                        chk("R4 R5 R9 period", mode_toggle, expm);
                    else
                        chk("R4 period", mode_toggle, expm);
                    if (expm)
                        chk("R2 pass", latch_en, ctrl_bits);
                    else
                        chk("R3 hold zero", latch_en, 0);
                end
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule